// File: doc/BRIEF.md
# Memory Channel Performance Monitor Box

This block counts events for one memory channel. It has four programmable event counters and one fixed counter. Each counter is 48 bits wide and has its own control word. Software reads and writes every register through a single 32-bit configuration port, addressed by byte offset. The channel logic supplies a vector of single-cycle event pulses. A generic counter picks one line of that vector with its select field. The fixed counter advances once per clock.

A box-wide control word does three things. It can stop every counter at once. It can clear all counter values. It can clear all counter control words. A box-wide status word latches a wrap of any counter. Software clears a status bit by writing 1 to it.

Freezing is handled by a two-state machine. In state BOX_RUN counters may advance. A box-control write with bit 8 set takes the FREEZE transition to BOX_FROZEN. A box-control write with bit 8 clear takes the THAW transition back to BOX_RUN. Any other write leaves the state as it is.

Top module: `mcpm_box`

## Requirements
- R1: After reset, every counter value, every control word and the status word read 0, and the box is in BOX_RUN.
- R2: The register offsets are as follows. Offsets not listed read 0, and writes to them change nothing.
  - Box control: 0xF4.
  - Status: 0xF8.
  - Generic control words: 0xD8, 0xDC, 0xE0 and 0xE4.
  - Fixed control word: 0xF0.
  - Generic counter low/high words: 0xA0/0xA4, 0xA8/0xAC, 0xB0/0xB4 and 0xB8/0xBC.
  - Fixed counter low/high words: 0xD0/0xD4.
- R3: A generic control word keeps only bits 7:0 (event select) and bit 22 (enable); all its other bits read 0. The fixed control word keeps only bit 22.
- R4: A generic counter adds one at a clock edge only when all of these hold: its enable is 1, the box is in BOX_RUN, and event line `evt_in[select]` is 1. A select value of NUM_EVT or more never counts.
- R5: The fixed counter adds one at every clock edge while its enable is 1 and the box is in BOX_RUN.
- R6: Bit 8 of box control is the freeze bit, and it reads back. While frozen, all five counters hold their values.
- R7: Writing box control with bit 1 set clears all five counter values at that edge. This clear wins over an increment in the same cycle. Bits 1 and 0 always read 0.
- R8: Writing box control with bit 0 set clears all five control words. Counter values are kept.
- R9: A counter's low and high words are writable. Only bits 15:0 of the high word are stored, and bits 31:16 read 0. A word write wins over an increment in the same cycle.
- R10: A counter wrap from all ones to zero sets its status bit. Bits 0 to 3 belong to generic counters 0 to 3, and bit 4 belongs to the fixed counter.
- R11: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a wrap and a clear of the same bit fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| evt_in | input | NUM_EVT | Event pulses from the channel logic |

## Verification
Two pairs of actions can land in the same cycle, and the bench provokes both on purpose.

The first pair is a counter wrap and a software clear of that same status bit. The bench preloads counter 2 to all ones. It then raises that counter's event line in the same cycle as a write of 1 to status bit 2. It expects the bit to read back as set and the counter to read zero.

The second pair is a reset-counters write and a live event. The bench holds the event line high through the box-control write. It expects the counter to read zero afterwards. A behavioural model in the bench checks every other cycle as well.

// File: rtl/mcpm_pkg.sv
package mcpm_pkg;
    localparam int NUM_GEN = 4;
    localparam int NUM_CTR = NUM_GEN + 1;
    localparam int FIX_IDX = NUM_GEN;
    localparam int SEL_W   = 8;
    localparam int BIT_RST_CTL = 0;
    localparam int BIT_RST_CNT = 1;
    localparam int BIT_FRZ     = 8;
    localparam int BIT_EN      = 22;

    localparam logic [7:0] OFS_BOX_CTL  = 8'hF4;
    localparam logic [7:0] OFS_BOX_STAT = 8'hF8;

    typedef enum logic [0:0] {BOX_RUN, BOX_FROZEN} box_state_e;

    function automatic logic [7:0] ctl_ofs(input int idx);
        return (idx == FIX_IDX) ? 8'hF0 : 8'(8'hD8 + 4 * idx);
    endfunction

    function automatic logic [7:0] lo_ofs(input int idx);
        return (idx == FIX_IDX) ? 8'hD0 : 8'(8'hA0 + 8 * idx);
    endfunction

    function automatic logic [7:0] hi_ofs(input int idx);
        return 8'(lo_ofs(idx) + 8'd4);
    endfunction
endpackage

// File: rtl/mcpm_box_fsm.sv
module mcpm_box_fsm
    import mcpm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        box_we,
    input  logic [31:0] wdata,
    output logic        frozen,
    output logic        rst_ctrl_p,
    output logic        rst_ctrs_p
);
    box_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BOX_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (box_we) begin
            unique case (state_q)
                BOX_RUN:    if (wdata[BIT_FRZ])  state_d = BOX_FROZEN;
                BOX_FROZEN: if (!wdata[BIT_FRZ]) state_d = BOX_RUN;
                default:    state_d = BOX_RUN;
            endcase
        end
    end

    always_comb begin
        frozen     = (state_q == BOX_FROZEN);
        rst_ctrl_p = box_we && wdata[BIT_RST_CTL];
        rst_ctrs_p = box_we && wdata[BIT_RST_CNT];
    end

    // R6: a box-control write sets the freeze state to its bit 8
    a_r6_freeze_follows: assert property (@(posedge clk) disable iff (!rst_n)
        box_we |=> (frozen == $past(wdata[BIT_FRZ])));
    // R6: with no box-control write, the freeze state does not move
    a_r6_freeze_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !box_we |=> $stable(frozen));
endmodule

// File: rtl/mcpm_counter.sv
module mcpm_counter
    import mcpm_pkg::*;
#(
    parameter int CNT_W    = 48,
    parameter int NUM_EVT  = 16,
    parameter bit IS_FIXED = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frozen,
    input  logic               rst_ctrs,
    input  logic               rst_ctrl,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               ctl_we,
    input  logic               lo_we,
    input  logic               hi_we,
    input  logic [31:0]        wdata,
    output logic [31:0]        ctl_rd,
    output logic [CNT_W-1:0]   cnt_q,
    output logic               wrap
);
    localparam int HI_W   = CNT_W - 32;
    localparam int EVT_IW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    logic en_q;
    logic hit;
    logic inc;

    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 1'b0;
        else if (rst_ctrl) en_q <= 1'b0;
        else if (ctl_we) en_q <= wdata[BIT_EN];
    end

    generate
        if (IS_FIXED) begin : g_fixed
            assign hit    = 1'b1;
            assign ctl_rd = {9'b0, en_q, 22'b0};
        end else begin : g_gen
            logic [SEL_W-1:0] sel_q;
            always_ff @(posedge clk) begin
                if (!rst_n)        sel_q <= '0;
                else if (rst_ctrl) sel_q <= '0;
                else if (ctl_we)   sel_q <= wdata[SEL_W-1:0];
            end
            assign hit    = (int'(sel_q) < NUM_EVT) && evt[sel_q[EVT_IW-1:0]];
            assign ctl_rd = {9'b0, en_q, 14'b0, sel_q};
        end
    endgenerate

    assign inc  = en_q && !frozen && hit;
    assign wrap = inc && (&cnt_q) && !rst_ctrs && !lo_we && !hi_we;

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (rst_ctrs) cnt_q <= '0;
        else if (lo_we)    cnt_q[31:0] <= wdata;
        else if (hi_we)    cnt_q[CNT_W-1:32] <= wdata[HI_W-1:0];
        else if (inc)      cnt_q <= cnt_q + 1'b1;
    end

    // R6: frozen with no write or clear, the value holds
    a_r6_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        frozen && !rst_ctrs && !lo_we && !hi_we |=> $stable(cnt_q));
    // R7: reset-counters empties the counter
    a_r7_ctrs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rst_ctrs |=> (cnt_q == '0));
    // R8: reset-control empties the control word
    a_r8_ctl_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rst_ctrl |=> (ctl_rd == 32'h0));
    // R10: a wrap leaves the counter at zero
    a_r10_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));
    // R4: a disabled counter with no write or clear holds its value
    a_r4_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q && !rst_ctrs && !lo_we && !hi_we |=> $stable(cnt_q));
endmodule

// File: rtl/mcpm_status.sv
module mcpm_status #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] ov_q
);
    logic [N-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) ov_q <= '0;
        else        ov_q <= (ov_q & ~clr_eff) | set;
    end

    // R10 / R11: a wrap always lands, even against a clear in the same cycle
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((ov_q & $past(set)) == $past(set)));
    // R11: a written 1 clears its bit unless a wrap arrives with it
    a_r11_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((ov_q & $past(clr_mask) & ~$past(set)) == '0));
    // R11: a written 0 keeps an already-set bit
    a_r11_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((ov_q & $past(ov_q & ~clr_mask)) == $past(ov_q & ~clr_mask)));
endmodule

// File: rtl/mcpm_box.sv
module mcpm_box
    import mcpm_pkg::*;
#(
    parameter int CNT_W   = 48,
    parameter int NUM_EVT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic [NUM_EVT-1:0] evt_in
);
    localparam int HI_W = CNT_W - 32;

    logic               frozen, rst_ctrl_p, rst_ctrs_p;
    logic               box_we, stat_we;
    logic [NUM_CTR-1:0] wrap_v;
    logic [NUM_CTR-1:0] ov;
    logic [31:0]        ctl_rd [NUM_CTR];
    logic [CNT_W-1:0]   cnt    [NUM_CTR];

    assign box_we  = cfg_we && (cfg_addr == OFS_BOX_CTL);
    assign stat_we = cfg_we && (cfg_addr == OFS_BOX_STAT);

    mcpm_box_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .box_we     (box_we),
        .wdata      (cfg_wdata),
        .frozen     (frozen),
        .rst_ctrl_p (rst_ctrl_p),
        .rst_ctrs_p (rst_ctrs_p)
    );

    generate
        for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
            mcpm_counter #(
                .CNT_W    (CNT_W),
                .NUM_EVT  (NUM_EVT),
                .IS_FIXED (i == FIX_IDX)
            ) u_ctr (
                .clk      (clk),
                .rst_n    (rst_n),
                .frozen   (frozen),
                .rst_ctrs (rst_ctrs_p),
                .rst_ctrl (rst_ctrl_p),
                .evt      (evt_in),
                .ctl_we   (cfg_we && (cfg_addr == ctl_ofs(i))),
                .lo_we    (cfg_we && (cfg_addr == lo_ofs(i))),
                .hi_we    (cfg_we && (cfg_addr == hi_ofs(i))),
                .wdata    (cfg_wdata),
                .ctl_rd   (ctl_rd[i]),
                .cnt_q    (cnt[i]),
                .wrap     (wrap_v[i])
            );
        end
    endgenerate

    mcpm_status #(.N(NUM_CTR)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (wrap_v),
        .clr_we   (stat_we),
        .clr_mask (cfg_wdata[NUM_CTR-1:0]),
        .ov_q     (ov)
    );

    always_comb begin
        cfg_rdata = 32'h0;
        if (cfg_addr == OFS_BOX_CTL)  cfg_rdata[BIT_FRZ] = frozen;
        if (cfg_addr == OFS_BOX_STAT) cfg_rdata = {{(32-NUM_CTR){1'b0}}, ov};
        for (int i = 0; i < NUM_CTR; i++) begin
            if (cfg_addr == ctl_ofs(i)) cfg_rdata = ctl_rd[i];
            if (cfg_addr == lo_ofs(i))  cfg_rdata = cnt[i][31:0];
            if (cfg_addr == hi_ofs(i))  cfg_rdata = {{(32-HI_W){1'b0}}, cnt[i][CNT_W-1:32]};
        end
    end

    // R2: offsets below the counter window read zero
    a_r2_low_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr < 8'hA0) |-> (cfg_rdata == 32'h0));
    // R9: upper bits of any high word read zero
    a_r9_hi_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_addr == 8'hD4) || ((cfg_addr >= 8'hA4) && (cfg_addr <= 8'hBC) && cfg_addr[2]))
        |-> (cfg_rdata[31:HI_W] == '0));
endmodule

// File: tb/test_mcpm_box.sv
`timescale 1ns/1ps
module test_mcpm_box;
    localparam int  NEVT = 16;
    localparam longint unsigned MAXV = 64'h0000_FFFF_FFFF_FFFF;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [7:0]      cfg_addr = 8'h00;
    logic [31:0]     cfg_wdata = 32'h0;
    logic [31:0]     cfg_rdata;
    logic [NEVT-1:0] evt_in = '0;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    mcpm_box #(.CNT_W(48), .NUM_EVT(NEVT)) i_mcpm_box (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .evt_in(evt_in)
    );

    // ---------------- behavioural reference model ----------------
    longint unsigned m_cnt [5];
    logic [31:0]     m_ctl [5];
    logic [4:0]      m_ov;
    bit              m_frz;
    bit   [4:0]      m_inc;
    logic [4:0]      m_set;

    function automatic logic [7:0] m_ctl_a(int i);
        return (i == 4) ? 8'hF0 : 8'(8'hD8 + 4 * i);
    endfunction
    function automatic logic [7:0] m_lo_a(int i);
        return (i == 4) ? 8'hD0 : 8'(8'hA0 + 8 * i);
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        logic [31:0] r = 32'h0;
        if (a == 8'hF4) r[8] = m_frz;
        if (a == 8'hF8) r = {27'b0, m_ov};
        for (int i = 0; i < 5; i++) begin
            if (a == m_ctl_a(i))           r = m_ctl[i];
            if (a == m_lo_a(i))            r = m_cnt[i][31:0];
            if (a == 8'(m_lo_a(i) + 4))    r = {16'h0, m_cnt[i][47:32]};
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) begin m_cnt[i] = 0; m_ctl[i] = 0; end
            m_ov = 0; m_frz = 0;
        end else begin
            m_set = 0;
            for (int i = 0; i < 5; i++) begin
                if (i == 4) m_inc[i] = m_ctl[i][22] && !m_frz;
                else m_inc[i] = m_ctl[i][22] && !m_frz && (m_ctl[i][7:0] < NEVT)
                                && evt_in[m_ctl[i][3:0]];
            end
            for (int i = 0; i < 5; i++) begin
                if (cfg_we && cfg_addr == 8'hF4 && cfg_wdata[1]) m_cnt[i] = 0;
                else if (cfg_we && cfg_addr == m_lo_a(i))
                    m_cnt[i] = {m_cnt[i][63:32], cfg_wdata};
                else if (cfg_we && cfg_addr == 8'(m_lo_a(i) + 4))
                    m_cnt[i] = {32'h0, cfg_wdata[15:0], m_cnt[i][31:0]};
                else if (m_inc[i]) begin
                    if (m_cnt[i] == MAXV) begin m_cnt[i] = 0; m_set[i] = 1'b1; end
                    else m_cnt[i] = m_cnt[i] + 1;
                end
                if (cfg_we && cfg_addr == 8'hF4 && cfg_wdata[0]) m_ctl[i] = 0;
                else if (cfg_we && cfg_addr == m_ctl_a(i))
                    m_ctl[i] = cfg_wdata & ((i == 4) ? 32'h0040_0000 : 32'h0040_00FF);
            end
            if (cfg_we && cfg_addr == 8'hF4) m_frz = cfg_wdata[8];
            if (cfg_we && cfg_addr == 8'hF8) m_ov = m_ov & ~cfg_wdata[4:0];
            m_ov = m_ov | m_set;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model, R2 addressing of whatever is on the port
    always @(posedge clk) begin
        #1;
        if (rst_n) chk("R2 model", cfg_rdata, m_read(cfg_addr));
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); cfg_we = 1'b0; cfg_addr = a;
        #1; d = cfg_rdata;
    endtask

    task automatic rdchk(string tag, logic [7:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic pulse(logic [NEVT-1:0] v);
        @(negedge clk); evt_in = v;
        @(negedge clk); evt_in = '0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdchk("R1 ctr0 lo", 8'hA0, 0);
        rdchk("R1 fixed ctl", 8'hF0, 0);
        rdchk("R1 status", 8'hF8, 0);
        rdchk("R1 box ctl", 8'hF4, 0);

        // R3 control layout
        wr(8'hDC, 32'hFFFF_FFFF);
        rdchk("R3 generic ctl mask", 8'hDC, 32'h0040_00FF);
        wr(8'hF0, 32'hFFFF_FFFF);
        rdchk("R3 fixed ctl mask", 8'hF0, 32'h0040_0000);
        wr(8'hF0, 32'h0);
        wr(8'hD4, 32'h0); wr(8'hD0, 32'h0);

        // R4 event select
        wr(8'hD8, 32'h0040_0003);
        for (int k = 0; k < 5; k++) begin pulse(16'h0008); pulse(16'hFFF7); end
        pulse(16'hFFFF);
        rdchk("R4 ctr0 count", 8'hA0, 32'd6);
        rdchk("R4 select >= NUM_EVT never counts", 8'hA8, 32'd0);

        // R5 fixed counter
        wr(8'hF0, 32'h0040_0000);
        repeat (10) @(negedge clk);
        wr(8'hF0, 32'h0);
        rdchk("R5 fixed per-cycle", 8'hD0, 32'd12);

        // R7 reset counters colliding with a live event
        evt_in = 16'h0008;
        wr(8'hF4, 32'h0000_0002);
        evt_in = '0;
        rdchk("R7 ctr0 cleared", 8'hA0, 0);
        rdchk("R7 fixed cleared", 8'hD0, 0);
        rdchk("R7 reset bits read 0", 8'hF4, 0);

        // R6 freeze
        wr(8'hF0, 32'h0040_0000);
        repeat (3) @(negedge clk);
        wr(8'hF4, 32'h0000_0100);
        rdchk("R6 freeze readback", 8'hF4, 32'h0000_0100);
        rd(8'hD0, a);
        pulse(16'h0008);
        repeat (4) @(negedge clk);
        rd(8'hD0, b);
        chk("R6 fixed held", b, a);
        rdchk("R6 ctr0 held", 8'hA0, 0);
        wr(8'hF4, 32'h0);

        // R8 reset control
        repeat (2) @(negedge clk);
        wr(8'hF4, 32'h0000_0001);
        rdchk("R8 ctl0 cleared", 8'hD8, 0);
        rdchk("R8 fixed ctl cleared", 8'hF0, 0);
        rd(8'hD0, a);
        chk("R8 count kept", 32'(a != 0), 32'd1);
        repeat (3) @(negedge clk);
        rdchk("R8 count idle", 8'hD0, a);

        // R9 / R10 wrap on counter 2
        wr(8'hB0, 32'hFFFF_FFFE);
        wr(8'hB4, 32'hFFFF_FFFF);
        rdchk("R9 hi word upper bits", 8'hB4, 32'h0000_FFFF);
        wr(8'hE0, 32'h0040_0005);
        pulse(16'h0020);
        rdchk("R10 no wrap yet", 8'hF8, 0);
        pulse(16'h0020);
        rdchk("R10 wrapped lo", 8'hB0, 0);
        rdchk("R10 wrapped hi", 8'hB4, 0);
        rdchk("R10 status bit2", 8'hF8, 32'h4);

        // R11 write-one-to-clear
        wr(8'hF8, 32'h0);
        rdchk("R11 zero keeps", 8'hF8, 32'h4);
        wr(8'hF8, 32'h1B);
        rdchk("R11 other bits keep", 8'hF8, 32'h4);
        wr(8'hF8, 32'h4);
        rdchk("R11 cleared", 8'hF8, 0);

        // R9 word write wins over increment
        @(negedge clk); evt_in = 16'h0020; cfg_we = 1'b1; cfg_addr = 8'hB0; cfg_wdata = 32'h100;
        @(negedge clk); evt_in = '0; cfg_we = 1'b0;
        rdchk("R9 write beats event", 8'hB0, 32'h100);

        // R11 wrap against clear in the same cycle
        wr(8'hB0, 32'hFFFF_FFFF);
        wr(8'hB4, 32'h0000_FFFF);
        @(negedge clk); evt_in = 16'h0020; cfg_we = 1'b1; cfg_addr = 8'hF8; cfg_wdata = 32'h4;
        @(negedge clk); evt_in = '0; cfg_we = 1'b0;
        rdchk("R11 set wins over clear", 8'hF8, 32'h4);
        rdchk("R10 ctr2 zero after wrap", 8'hB0, 0);

        // R10 fixed counter wrap maps to bit 4
        wr(8'hD0, 32'hFFFF_FFFF);
        wr(8'hD4, 32'h0000_FFFF);
        wr(8'hF0, 32'h0040_0000);
        wr(8'hF0, 32'h0);
        rdchk("R10 fixed wrap bit4", 8'hF8, 32'h14);
        wr(8'hF8, 32'h1F);
        rdchk("R11 clear all", 8'hF8, 0);

        // R2 unmapped offsets
        wr(8'hC0, 32'hFFFF_FFFF);
        rdchk("R2 unmapped C0", 8'hC0, 0);
        rdchk("R2 unmapped 00", 8'h00, 0);
        rdchk("R2 unmapped FC", 8'hFC, 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule